// File: doc/BRIEF.md
# BT host register interface

This block is the host-facing side of a block-transfer management mailbox. It has one byte-wide register window with three registers. A control and status register sits at offset 0, a buffer data port at offset 1 and an interrupt mask at offset 2. The host fills a request buffer through the data port and then raises the host-to-controller attention bit. That sets the controller busy flag and sends a one-cycle ready pulse to the message processor. The message processor reads the stored request through a side index port.

The processor writes the response bytes through a separate load port and commits a length. The commit clears the controller busy flag and sets the controller-to-host attention flag. The host then drains the response through the same data port. A second attention source, the system-management attention, is set and cleared from the processor side. Both attention sources reach one level interrupt through an enable bit and a pending bit.

Top module: `bt_host_regs`

## Requirements
- R1: After reset the control register reads 0x00, the mask register reads 0x00, the data port reads 0xFF, the request length is 0 and `irq_o` is low.
- R2: Writing a control byte with bit 0 set returns the request length to 0.
- R3: Each data-port write stores its byte at index `req_len_o` only while the length is below the buffer depth. The length rises by one on every data-port write and holds at its all-ones value. Bytes beyond the depth are dropped and never overwrite stored ones.
- R4: Writing a control byte with bit 1 set moves the response read position back to the first byte.
- R5: A data-port read returns the next committed response byte and advances. After the last byte, position and length both return to 0. A read with nothing pending returns 0xFF.
- R6: In the control register, writing 1 to bit 3 clears controller-to-host attention and writing 1 to bit 4 clears system-management attention. Writing 1 to bit 6 toggles host busy. Read layout: bit 7 controller busy, bit 6 host busy, bit 4 system-management attention, bit 3 controller-to-host attention; all other bits read 0.
- R7: Writing a control byte with bit 2 set sets controller busy (bit 7). On the next cycle `req_ready_o` is high for exactly one cycle.
- R8: A response commit clears controller busy, sets controller-to-host attention and, if the enable is set, sets pending.
- R9: In the mask register, bit 0 is the enable and bit 1 is pending. Turning the enable on while either attention flag is set sets pending. Turning it off clears pending.
- R10: Writing 1 to mask bit 1 while pending is set clears pending.
- R11: A system-management set with its interrupt flag raises pending only if controller-to-host attention is clear and the enable is set. A system-management clear drops pending if controller-to-host attention is clear.
- R12: A `cold_rst_i` pulse clears pending and enable.
- R13: `irq_o` is high exactly when pending is set and `irq_allow_i` is high.
- R14: The window is decoded on the low `WIN_W` address bits, so addresses alias. An offset above 2 reads 0xFF, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cold_rst_i | input | 1 | Cold reset pulse for interrupt enable and pending |
| irq_allow_i | input | 1 | Global interrupt allow |
| host_addr_i | input | ADDR_W | Host byte address |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the current address |
| req_ready_o | output | 1 | One-cycle request-ready pulse |
| req_len_o | output | LEN_W | Request byte count |
| req_idx_i | input | IDX_W | Request buffer read index |
| req_data_o | output | 8 | Request byte at `req_idx_i` |
| rsp_wr_i | input | 1 | Response byte load strobe |
| rsp_idx_i | input | IDX_W | Response byte load index |
| rsp_data_i | input | 8 | Response byte |
| rsp_commit_i | input | 1 | Response commit strobe |
| rsp_len_i | input | CNT_W | Committed response length |
| sms_set_i | input | 1 | Set system-management attention |
| sms_clr_i | input | 1 | Clear system-management attention |
| sms_irq_i | input | 1 | Set may raise the interrupt |
| irq_o | output | 1 | Level interrupt |

## Verification
Register reads are combinational, so the bench samples `host_rdata_o` in the cycle the address is driven, one time unit after the falling edge. A write, commit or side-band event takes effect at the next rising edge. Its result is read back on the following falling edge. `req_ready_o` is registered. It is checked on the first falling edge after the write edge, and again one cycle later to see it drop. `irq_o` follows pending in the cycle after the event and follows `irq_allow_i` combinationally, and the bench samples it at the falling edge on that basis.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int OFF_CTL = 0;
  localparam int OFF_DAT = 1;
  localparam int OFF_MSK = 2;

  // control bit positions (host-visible behaviour depends on them)
  localparam int CB_CLR_WR = 0;
  localparam int CB_CLR_RD = 1;
  localparam int CB_GO     = 2;
  localparam int CB_C2H    = 3;
  localparam int CB_SMS    = 4;
  localparam int CB_HBUSY  = 6;
  localparam int CB_CBUSY  = 7;

  localparam int MB_EN   = 0;
  localparam int MB_PEND = 1;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic       ctl_wr;
    logic       dat_wr;
    logic       msk_wr;
    logic       dat_rd;
    logic [7:0] wdata;
  } bt_acc_t;
endpackage

// File: rtl/bt_wbuf.sv
module bt_wbuf #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [7:0]       data_i,
  output logic [LEN_W-1:0] len_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(DEPTH);

  logic [7:0]       mem_q [DEPTH];
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else if (clr_i) begin
      len_q <= '0;
    end else if (wr_i && (len_q != '1)) begin
      len_q <= len_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i && (len_q < CAP)) mem_q[len_q[IDX_W-1:0]] <= data_i;
  end

  assign len_o     = len_q;
  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/bt_rbuf.sv
module bt_rbuf #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic [7:0]       load_data_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] commit_len_i,
  input  logic             clr_pos_i,
  input  logic             rd_i,
  output logic [7:0]       data_o,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] pos_q, len_q;
  logic             avail;

  assign avail = pos_q < len_q;

  always_ff @(posedge clk_i) begin
    if (load_i) mem_q[load_idx_i] <= load_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      len_q <= '0;
    end else if (commit_i) begin
      pos_q <= '0;
      len_q <= (commit_len_i > CAP) ? CAP : commit_len_i;
    end else if (clr_pos_i) begin
      pos_q <= '0;
    end else if (rd_i && avail) begin
      if (pos_q + 1'b1 == len_q) begin
        pos_q <= '0;
        len_q <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign data_o = avail ? mem_q[pos_q[IDX_W-1:0]] : bt_pkg::IDLE_BYTE;
  assign len_o  = len_q;
endmodule

// File: rtl/bt_irq_ctl.sv
module bt_irq_ctl
  import bt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cold_rst_i,
  input  logic       ctl_wr_i,
  input  logic       msk_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rsp_commit_i,
  input  logic       sms_set_i,
  input  logic       sms_clr_i,
  input  logic       sms_irq_i,
  output logic [7:0] ctl_byte_o,
  output logic [7:0] msk_byte_o,
  output logic       pend_o,
  output logic       req_ready_o
);
  logic c2h_q, sms_q, cbusy_q, hbusy_q, en_q, pend_q, rdy_q;
  logic c2h_n, sms_n, cbusy_n, hbusy_n, en_n, pend_n;

  // events applied in a fixed order: commit, side band, host write, cold reset
  always_comb begin
    c2h_n   = c2h_q;
    sms_n   = sms_q;
    cbusy_n = cbusy_q;
    hbusy_n = hbusy_q;
    en_n    = en_q;
    pend_n  = pend_q;

    if (rsp_commit_i) begin
      cbusy_n = 1'b0;
      c2h_n   = 1'b1;
      if (en_n) pend_n = 1'b1;
    end

    if (sms_set_i && !sms_n) begin
      sms_n = 1'b1;
      if (sms_irq_i && !c2h_n && en_n) pend_n = 1'b1;
    end else if (sms_clr_i && sms_n) begin
      sms_n = 1'b0;
      if (!c2h_n) pend_n = 1'b0;
    end

    if (ctl_wr_i) begin
      if (wdata_i[CB_C2H])   c2h_n   = 1'b0;
      if (wdata_i[CB_SMS])   sms_n   = 1'b0;
      if (wdata_i[CB_HBUSY]) hbusy_n = ~hbusy_n;
      if (wdata_i[CB_GO])    cbusy_n = 1'b1;
    end

    if (msk_wr_i) begin
      if (wdata_i[MB_EN] != en_n) begin
        if (wdata_i[MB_EN]) begin
          if (c2h_n || sms_n) pend_n = 1'b1;
          en_n = 1'b1;
        end else begin
          pend_n = 1'b0;
          en_n   = 1'b0;
        end
      end
      if (wdata_i[MB_PEND]) pend_n = 1'b0;
    end

    if (cold_rst_i) begin
      pend_n = 1'b0;
      en_n   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2h_q   <= 1'b0;
      sms_q   <= 1'b0;
      cbusy_q <= 1'b0;
      hbusy_q <= 1'b0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      c2h_q   <= c2h_n;
      sms_q   <= sms_n;
      cbusy_q <= cbusy_n;
      hbusy_q <= hbusy_n;
      en_q    <= en_n;
      pend_q  <= pend_n;
      rdy_q   <= ctl_wr_i && wdata_i[CB_GO];
    end
  end

  always_comb begin
    ctl_byte_o            = '0;
    ctl_byte_o[CB_C2H]    = c2h_q;
    ctl_byte_o[CB_SMS]    = sms_q;
    ctl_byte_o[CB_HBUSY]  = hbusy_q;
    ctl_byte_o[CB_CBUSY]  = cbusy_q;
    msk_byte_o            = '0;
    msk_byte_o[MB_EN]     = en_q;
    msk_byte_o[MB_PEND]   = pend_q;
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[5], wdata_i[7], wdata_i[1:0]};

  assign pend_o      = pend_q;
  assign req_ready_o = rdy_q;
endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs
  import bt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIN_W     = 2,
  parameter int BUF_DEPTH = 64,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int CNT_W = $clog2(BUF_DEPTH + 1),
  localparam int LEN_W = $clog2(BUF_DEPTH) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_rst_i,
  input  logic              irq_allow_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic              req_ready_o,
  output logic [LEN_W-1:0]  req_len_o,
  input  logic [IDX_W-1:0]  req_idx_i,
  output logic [7:0]        req_data_o,
  input  logic              rsp_wr_i,
  input  logic [IDX_W-1:0]  rsp_idx_i,
  input  logic [7:0]        rsp_data_i,
  input  logic              rsp_commit_i,
  input  logic [CNT_W-1:0]  rsp_len_i,
  input  logic              sms_set_i,
  input  logic              sms_clr_i,
  input  logic              sms_irq_i,
  output logic              irq_o
);
  logic [WIN_W-1:0] host_off;
  bt_acc_t          acc;
  logic [7:0]       ctl_byte, msk_byte, rsp_byte;
  logic [CNT_W-1:0] rsp_len_q;
  logic             pend;

  // size-masked decode: only the low WIN_W bits select a register
  assign host_off = host_addr_i[WIN_W-1:0];

  generate
    if (ADDR_W > WIN_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^host_addr_i[ADDR_W-1:WIN_W];
    end
  endgenerate

  always_comb begin
    acc.ctl_wr = host_wr_i && (host_off == WIN_W'(OFF_CTL));
    acc.dat_wr = host_wr_i && (host_off == WIN_W'(OFF_DAT));
    acc.msk_wr = host_wr_i && (host_off == WIN_W'(OFF_MSK));
    acc.dat_rd = host_rd_i && (host_off == WIN_W'(OFF_DAT));
    acc.wdata  = host_wdata_i;
  end

  bt_wbuf #(.DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) u_wbuf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (acc.ctl_wr && acc.wdata[CB_CLR_WR]),
    .wr_i     (acc.dat_wr),
    .data_i   (acc.wdata),
    .len_o    (req_len_o),
    .rd_idx_i (req_idx_i),
    .rd_data_o(req_data_o)
  );

  bt_rbuf #(.DEPTH(BUF_DEPTH)) u_rbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (rsp_wr_i),
    .load_idx_i  (rsp_idx_i),
    .load_data_i (rsp_data_i),
    .commit_i    (rsp_commit_i),
    .commit_len_i(rsp_len_i),
    .clr_pos_i   (acc.ctl_wr && acc.wdata[CB_CLR_RD]),
    .rd_i        (acc.dat_rd),
    .data_o      (rsp_byte),
    .len_o       (rsp_len_q)
  );

  bt_irq_ctl u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cold_rst_i  (cold_rst_i),
    .ctl_wr_i    (acc.ctl_wr),
    .msk_wr_i    (acc.msk_wr),
    .wdata_i     (acc.wdata),
    .rsp_commit_i(rsp_commit_i),
    .sms_set_i   (sms_set_i),
    .sms_clr_i   (sms_clr_i),
    .sms_irq_i   (sms_irq_i),
    .ctl_byte_o  (ctl_byte),
    .msk_byte_o  (msk_byte),
    .pend_o      (pend),
    .req_ready_o (req_ready_o)
  );

  always_comb begin
    if (host_off == WIN_W'(OFF_CTL))      host_rdata_o = ctl_byte;
    else if (host_off == WIN_W'(OFF_DAT)) host_rdata_o = rsp_byte;
    else if (host_off == WIN_W'(OFF_MSK)) host_rdata_o = msk_byte;
    else                                  host_rdata_o = IDLE_BYTE;
  end

  assign irq_o = pend && irq_allow_i;
endmodule

// File: rtl/bt_host_regs_chk.sv
module bt_host_regs_chk #(
  parameter int WIN_W = 2,
  parameter int LEN_W = 8,
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cold_rst_i,
  input logic             irq_allow_i,
  input logic             irq_o,
  input logic             host_wr_i,
  input logic [WIN_W-1:0] host_off,
  input logic [7:0]       host_wdata_i,
  input logic [7:0]       host_rdata_o,
  input logic             req_ready_o,
  input logic [LEN_W-1:0] req_len_o,
  input logic             rsp_commit_i,
  input logic [CNT_W-1:0] rsp_len_q,
  input logic [7:0]       ctl_byte
);
  logic go_wr, ctl_wr, dat_wr;
  assign ctl_wr = host_wr_i && (host_off == WIN_W'(0));
  assign go_wr  = ctl_wr && host_wdata_i[2];
  assign dat_wr = host_wr_i && (host_off == WIN_W'(1));

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_allow_i |-> !irq_o); // R13

  AST_GO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_wr |=> (req_ready_o && ctl_byte[7])); // R7

  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> $past(go_wr)); // R7

  AST_LEN_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr |=> ((req_len_o == $past(req_len_o) + 1'b1) ||
                (($past(req_len_o) == '1) && (req_len_o == '1)))); // R3

  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((host_off == WIN_W'(1)) && (rsp_len_q == '0)) |-> (host_rdata_o == 8'hFF)); // R5

  AST_OUT_OF_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_off > WIN_W'(2)) |-> (host_rdata_o == 8'hFF)); // R14

  AST_COMMIT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_commit_i && !ctl_wr) |=> (!ctl_byte[7] && ctl_byte[3])); // R8

  AST_COLD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_i |=> !irq_o); // R12
endmodule

bind bt_host_regs bt_host_regs_chk #(
  .WIN_W(WIN_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cold_rst_i  (cold_rst_i),
  .irq_allow_i (irq_allow_i),
  .irq_o       (irq_o),
  .host_wr_i   (host_wr_i),
  .host_off    (host_off),
  .host_wdata_i(host_wdata_i),
  .host_rdata_o(host_rdata_o),
  .req_ready_o (req_ready_o),
  .req_len_o   (req_len_o),
  .rsp_commit_i(rsp_commit_i),
  .rsp_len_q   (rsp_len_q),
  .ctl_byte    (ctl_byte)
);

// File: tb/bt_host_regs_tb.sv
module bt_host_regs_tb;
  localparam int CLK_P    = 10;
  localparam int DEPTH    = 64;
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int LEN_W    = $clog2(DEPTH) + 2;
  localparam int WDOG_MAX = 20000;

  // vector: {op[3:0], req[3:0], addr[7:0], data[7:0], exp[7:0]}
  // op 0 write, 1 read+check, 2 length check, 3 response commit (data=len), 4 ready-pulse check
  localparam int NV = 50;
  localparam logic [31:0] VEC [NV] = '{
    32'h11_00_00_00, // R1 control
    32'h11_02_00_00, // R1 mask
    32'h15_01_00_FF, // R5 empty read
    32'h03_01_11_00, // R3
    32'h03_01_22_00, // R3
    32'h03_01_33_00, // R3
    32'h23_00_00_03, // R3 length 3
    32'h02_00_01_00, // R2 clear write length
    32'h22_00_00_00, // R2
    32'h07_00_04_00, // R7 go
    32'h47_00_00_01, // R7 pulse high
    32'h47_00_00_00, // R7 pulse gone
    32'h17_00_00_80, // R7 controller busy
    32'h06_00_40_00, // R6 toggle host busy
    32'h16_00_00_C0, // R6
    32'h06_00_40_00, // R6
    32'h16_00_00_80, // R6
    32'h09_02_01_00, // R9 enable, no attention
    32'h19_02_00_01, // R9
    32'h38_00_03_00, // R8 commit 3 bytes
    32'h18_00_00_08, // R8 busy clear, attention set
    32'h18_02_00_03, // R8 pending
    32'h15_01_00_A0, // R5
    32'h15_01_00_A1, // R5
    32'h15_01_00_A2, // R5
    32'h15_01_00_FF, // R5 drained
    32'h0A_02_03_00, // R10 clear pending
    32'h1A_02_00_01, // R10
    32'h06_00_08_00, // R6 clear attention
    32'h16_00_00_00, // R6
    32'h09_02_00_00, // R9
    32'h19_02_00_00, // R9
    32'h1E_03_00_FF, // R14 hole reads FF
    32'h0E_03_FF_00, // R14 hole write
    32'h1E_00_00_00, // R14 nothing changed
    32'h0E_06_01_00, // R14 alias of mask
    32'h1E_02_00_01, // R14
    32'h0E_02_00_00, // R14
    32'h38_00_02_00, // R8 commit 2 bytes, enable off
    32'h18_02_00_00, // R8 no pending
    32'h18_00_00_08, // R8
    32'h09_02_01_00, // R9 enable with attention
    32'h19_02_00_03, // R9
    32'h09_02_00_00, // R9 disable
    32'h19_02_00_00, // R9
    32'h14_01_00_A0, // R4
    32'h04_00_02_00, // R4 rewind
    32'h14_01_00_A0, // R4
    32'h14_01_00_A1, // R4
    32'h14_01_00_FF  // R4
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cold_rst_i = 1'b0;
  logic             irq_allow_i = 1'b1;
  logic [7:0]       host_addr_i = '0;
  logic             host_wr_i = 1'b0;
  logic             host_rd_i = 1'b0;
  logic [7:0]       host_wdata_i = '0;
  logic [7:0]       host_rdata_o;
  logic             req_ready_o;
  logic [LEN_W-1:0] req_len_o;
  logic [IDX_W-1:0] req_idx_i = '0;
  logic [7:0]       req_data_o;
  logic             rsp_wr_i = 1'b0;
  logic [IDX_W-1:0] rsp_idx_i = '0;
  logic [7:0]       rsp_data_i = '0;
  logic             rsp_commit_i = 1'b0;
  logic [CNT_W-1:0] rsp_len_i = '0;
  logic             sms_set_i = 1'b0;
  logic             sms_clr_i = 1'b0;
  logic             sms_irq_i = 1'b0;
  logic             irq_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bt_host_regs #(.ADDR_W(8), .WIN_W(2), .BUF_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cold_rst_i(cold_rst_i), .irq_allow_i(irq_allow_i),
    .host_addr_i(host_addr_i), .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .req_ready_o(req_ready_o), .req_len_o(req_len_o), .req_idx_i(req_idx_i),
    .req_data_o(req_data_o), .rsp_wr_i(rsp_wr_i), .rsp_idx_i(rsp_idx_i),
    .rsp_data_i(rsp_data_i), .rsp_commit_i(rsp_commit_i), .rsp_len_i(rsp_len_i),
    .sms_set_i(sms_set_i), .sms_clr_i(sms_clr_i), .sms_irq_i(sms_irq_i), .irq_o(irq_o)
  );

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    host_addr_i = a; host_wdata_i = d; host_wr_i = 1'b1;
    @(negedge clk);
    host_wr_i = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] r);
    host_addr_i = a; host_rd_i = 1'b1;
    #1 r = host_rdata_o;
    @(negedge clk);
    host_rd_i = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] r);
    host_addr_i = a;
    #1 r = host_rdata_o;
  endtask

  task automatic rsp_load(input int n);
    for (int i = 0; i < n; i++) begin
      rsp_wr_i = 1'b1; rsp_idx_i = IDX_W'(i); rsp_data_i = 8'hA0 + 8'(i);
      @(negedge clk);
    end
    rsp_wr_i = 1'b0;
    rsp_commit_i = 1'b1; rsp_len_i = CNT_W'(n);
    @(negedge clk);
    rsp_commit_i = 1'b0;
  endtask

  task automatic pulse_side(input logic set, input logic clr, input logic irq);
    sms_set_i = set; sms_clr_i = clr; sms_irq_i = irq;
    @(negedge clk);
    sms_set_i = 1'b0; sms_clr_i = 1'b0; sms_irq_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_MAX && !done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(1, "irq after reset", {7'd0, irq_o}, 8'h00); // R1

    for (int k = 0; k < NV; k++) begin
      logic [3:0] op;
      logic [3:0] rq;
      logic [7:0] ad, dt, ex;
      {op, rq, ad, dt, ex} = VEC[k];
      case (op)
        4'd0: host_write(ad, dt);
        4'd1: begin host_read(ad, r); check(int'(rq), "table read", r, ex); end
        4'd2: begin check(int'(rq), "table length", req_len_o[7:0], ex); @(negedge clk); end
        4'd3: rsp_load(int'(dt));
        default: begin check(int'(rq), "ready pulse", {7'd0, req_ready_o}, ex); @(negedge clk); end
      endcase
    end

    // R3 overrun: count saturates, stored bytes are not overwritten
    host_write(8'h00, 8'h01);
    for (int i = 0; i < 300; i++) host_write(8'h01, 8'(i));
    check(3, "saturated length", req_len_o[7:0], 8'hFF);
    req_idx_i = '0;
    #1 check(3, "first stored byte", req_data_o, 8'h00);
    req_idx_i = IDX_W'(DEPTH - 1);
    #1 check(3, "last stored byte", req_data_o, 8'(DEPTH - 1));
    @(negedge clk);

    // R11 / R13: side-band attention
    host_write(8'h00, 8'h08);
    host_write(8'h02, 8'h01);
    pulse_side(1'b1, 1'b0, 1'b1);
    peek(8'h02, r); check(11, "sms set raises pending", r, 8'h03);
    check(13, "irq with allow", {7'd0, irq_o}, 8'h01);
    irq_allow_i = 1'b0;
    #1 check(13, "irq without allow", {7'd0, irq_o}, 8'h00);
    irq_allow_i = 1'b1;
    @(negedge clk);
    pulse_side(1'b0, 1'b1, 1'b0);
    peek(8'h02, r); check(11, "sms clear drops pending", r, 8'h01);
    check(13, "irq low after clear", {7'd0, irq_o}, 8'h00);
    pulse_side(1'b1, 1'b0, 1'b0);
    peek(8'h02, r); check(11, "sms set without irq flag", r, 8'h01);
    peek(8'h00, r); check(6, "sms flag visible", r, 8'h10);
    @(negedge clk);
    host_write(8'h00, 8'h10);
    peek(8'h00, r); check(6, "sms flag cleared by host", r, 8'h00);
    @(negedge clk);
    rsp_load(1);
    pulse_side(1'b0, 1'b0, 1'b0);
    host_write(8'h02, 8'h03);
    pulse_side(1'b1, 1'b0, 1'b1);
    peek(8'h02, r); check(11, "sms set blocked by attention", r, 8'h01);
    @(negedge clk);

    // R12 cold reset
    host_write(8'h02, 8'h00);
    host_write(8'h02, 8'h01);
    peek(8'h02, r); check(12, "pending before cold reset", r, 8'h03);
    @(negedge clk);
    cold_rst_i = 1'b1;
    @(negedge clk);
    cold_rst_i = 1'b0;
    peek(8'h02, r); check(12, "mask after cold reset", r, 8'h00);
    check(12, "irq after cold reset", {7'd0, irq_o}, 8'h00);
    @(negedge clk);

    // R1 full reset mid-run
    host_write(8'h01, 8'h55);
    host_write(8'h00, 8'h44);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    peek(8'h00, r); check(1, "control after reset", r, 8'h00);
    peek(8'h02, r); check(1, "mask after reset", r, 8'h00);
    peek(8'h01, r); check(1, "data after reset", r, 8'hFF);
    check(1, "length after reset", req_len_o[7:0], 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule